// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block runs clause 22 management transactions on an MDC/MDIO pair. A host reaches it through three 16-bit registers. Writing the command register starts one read or one write to a chosen PHY address and register number. The host then polls an idle flag until the transaction has finished. A read leaves the 16 bits returned by the PHY in a read-data register. A write sends a value that the host placed in a write-data register before it issued the command.

MDC comes from the system clock through a divider. Its half period is `CLK_DIV_HALF` system cycles, which must be at least 2. The default of 20 gives 2.5 MHz from a 100 MHz clock. The controller changes MDIO on falling MDC edges and samples read data on rising MDC edges. MDIO is split into separate output, output-enable and input pins, so a pad or the bench can build the tri-state line.

Top module: `mgmt_mdio_master`

## Requirements
- R1: Registers sit at byte offsets 0x0 (command/status), 0x2 (write data) and 0x4 (read data); other offsets read as 0. The write-data register reads back the last value written to it, and the read-data register reads 0 after reset.
- R2: A command that is accepted clears status bit 12 from the next cycle on. Bit 12 sets again once the frame ends, no more than 100 us after the command write when the system clock runs at 100 MHz.
- R3: In the command word, bits [4:0] give the PHY register number, bits [9:5] the PHY address and bits [11:10] the opcode (2 = read, 1 = write). The frame starts with 32 ones, then the start bits 01, then the opcode bits as sent on the wire (10 for a read, 01 for a write), then the 5-bit address MSB first, then the 5-bit register number MSB first.
- R4: A write frame ends with the turnaround 10 and then 16 data bits MSB first, with MDIO driven for all 64 bits. The data is the write-data value at the moment the command is accepted; writes to that register afterwards do not change the frame.
- R5: A read frame releases MDIO (output-enable low) for frame bits 46 to 63. The controller samples 16 bits, MSB first, on the rising MDC edges of frame bits 48 to 63. The read-data register holds those bits once bit 12 sets again.
- R6: While busy, MDC has a period of 2*CLK_DIV_HALF system cycles. MDIO and its output-enable never change in the cycle where MDC rises.
- R7: A command write while busy is ignored. A command with opcode 0 or 3 is ignored and leaves bit 12 set. An ignored command produces no frame.
- R8: The read-data register changes only when a read completes. Write transactions leave it unchanged.
- R9: After reset the controller is idle, with status 0x1000, MDC low and MDIO released.
- R10: Whenever the controller is idle, MDC is low and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, decoded from reg_addr_i without a clock delay |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit index or a lost shift position shows up on the wire straight away. Either the 46 header bits or the 64-bit output-enable pattern of that frame differs from the expected frame, and the scoreboard compares every frame when its 64th rising MDC edge arrives. A stuck busy state shows as bit 12 failing to set within the 100 us window. A false accept shows as an extra frame that was never expected. A sampling error lands in the read-data register and is caught when that register is read just after bit 12 sets again.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_BAD  = 2'd3
  } mdio_op_e;

  localparam int PRE_LEN   = 32;
  localparam int DATA_LEN  = 16;
  localparam int FRAME_LEN = 64;
  localparam int DRV_LEN   = FRAME_LEN - DATA_LEN - 2;  // bits driven during a read
  localparam int IDLE_BIT  = 12;

  localparam logic [2:0] OFS_CMD  = 3'h0;
  localparam logic [2:0] OFS_WDAT = 3'h2;
  localparam logic [2:0] OFS_RDAT = 3'h4;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int CLK_DIV_HALF = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (CLK_DIV_HALF > 1) ? $clog2(CLK_DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(CLK_DIV_HALF - 1));
  assign rise_o = wrap && !mdc_o;
  assign fall_o = wrap && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  mdio_op_e            op_i,
  input  logic [4:0]          phy_i,
  input  logic [4:0]          regn_i,
  input  logic [DATA_LEN-1:0] wdata_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                mdio_i,
  output logic                busy_o,
  output logic                mdio_o,
  output logic                mdio_oe_o,
  output logic                done_rd_o,
  output logic [DATA_LEN-1:0] rdata_o
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shift_q;
  logic [IW-1:0]        idx_q;
  logic                 rd_q;
  logic                 busy_q;
  logic [DATA_LEN-1:0]  rx_q;
  logic [DATA_LEN-1:0]  payload;
  logic                 last;

  assign payload   = (op_i == OP_RD) ? '0 : wdata_i;
  assign last      = (idx_q == IW'(FRAME_LEN - 1));
  assign busy_o    = busy_q;
  assign mdio_oe_o = busy_q && (!rd_q || (idx_q < IW'(DRV_LEN)));
  assign mdio_o    = mdio_oe_o && shift_q[FRAME_LEN-1];
  assign done_rd_o = busy_q && rd_q && fall_i && last;
  assign rdata_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
      rx_q    <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        shift_q <= {{PRE_LEN{1'b1}}, 2'b01, op_i, phy_i, regn_i, 2'b10, payload};
        idx_q   <= '0;
        rd_q    <= (op_i == OP_RD);
        busy_q  <= 1'b1;
      end
    end else begin
      // sample on rising MDC during the read data phase
      if (rise_i && rd_q && (idx_q >= IW'(FRAME_LEN - DATA_LEN)))
        rx_q <= {rx_q[DATA_LEN-2:0], mdio_i};
      // advance on falling MDC
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shift_q <= {shift_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_mdio_master.sv
`timescale 1ns/1ps
module mgmt_mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV_HALF = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [11:0]         cmd_q;
  logic [15:0]         wdat_q;
  logic [DATA_LEN-1:0] rdat_q;
  logic                busy_w;
  logic                cmd_wr_w;
  logic                accept_w;
  logic                rise_w;
  logic                fall_w;
  logic                done_rd_w;
  logic [DATA_LEN-1:0] eng_rdata_w;
  mdio_op_e            op_w;

  assign op_w     = mdio_op_e'(reg_wdata_i[11:10]);
  assign cmd_wr_w = reg_we_i && (reg_addr_i == OFS_CMD);
  assign accept_w = cmd_wr_w && !busy_w && ((op_w == OP_RD) || (op_w == OP_WR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (accept_w) cmd_q <= reg_wdata_i[11:0];
      if (reg_we_i && (reg_addr_i == OFS_WDAT)) wdat_q <= reg_wdata_i;
      if (done_rd_w) rdat_q <= eng_rdata_w;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_CMD:  reg_rdata_o = {3'b000, !busy_w, cmd_q};
      OFS_WDAT: reg_rdata_o = wdat_q;
      OFS_RDAT: reg_rdata_o = rdat_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  mdio_clk_div #(.CLK_DIV_HALF(CLK_DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_w),
    .mdc_o  (mdc_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept_w),
    .op_i      (op_w),
    .phy_i     (reg_wdata_i[9:5]),
    .regn_i    (reg_wdata_i[4:0]),
    .wdata_i   (wdat_q),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .mdio_i    (mdio_i),
    .busy_o    (busy_w),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_rd_o (done_rd_w),
    .rdata_o   (eng_rdata_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        accept_i,
  input logic        cmd_wr_i,
  input logic [1:0]  cmd_op_i,
  input logic [11:0] cmd_q_i,
  input logic [15:0] rdat_q_i,
  input logic        done_rd_i,
  input logic        mdc_i,
  input logic        mdio_o_i,
  input logic        mdio_oe_i
);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> busy_i);

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr_i) |=> $stable(cmd_q_i));

  // R7
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && ((cmd_op_i == 2'd0) || (cmd_op_i == 2'd3))) |=> !busy_i);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i));

  // R6
  mdc_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_i) |-> ($stable(mdio_o_i) && $stable(mdio_oe_i)));

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdat_q_i) |-> $past(done_rd_i));
endmodule

bind mgmt_mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_w),
  .accept_i  (accept_w),
  .cmd_wr_i  (cmd_wr_w),
  .cmd_op_i  (reg_wdata_i[11:10]),
  .cmd_q_i   (cmd_q),
  .rdat_q_i  (rdat_q),
  .done_rd_i (done_rd_w),
  .mdc_i     (mdc_o),
  .mdio_o_i  (mdio_o),
  .mdio_oe_i (mdio_oe_o)
);

// File: tb/mgmt_mdio_master_tb_top.sv
`timescale 1ns/1ps
module mgmt_mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        phy_drv = 1'b1;
  logic [15:0] resp_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  int frames_exp = 0;
  int frames_seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic        rd;
    logic [63:0] bits;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_mdio_master #(.CLK_DIV_HALF(HALF)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .mdc_o       (mdc),
    .mdio_o      (mdio_out),
    .mdio_oe_o   (mdio_oe),
    .mdio_i      (phy_drv)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int cyc = 0;
    s = '0;
    while (!s[12] && cyc < 20000) begin
      reg_read(3'h0, s);
      cyc++;
    end
    // R2: idle again within 100 us (10000 cycles at 100 MHz)
    chk(s[12] && cyc <= 10000, "R2", 64'(cyc), 64'd10000);
  endtask

  // driver: pushes the expected frame, then issues the command
  task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rn,
                         input logic [15:0] d);
    exp_t e;
    e.rd   = (op == 2'd2);
    e.bits = {32'hFFFF_FFFF, 2'b01, op, phy, rn, 2'b10, (e.rd ? 16'h0 : d)};
    if (e.rd) resp_data = d;
    else      reg_write(3'h2, d);
    exp_q.push_back(e);
    frames_exp++;
    reg_write(3'h0, {4'h0, op, phy, rn});
  endtask

  // monitor and PHY responder
  initial begin
    logic [63:0] bits, oes, mask, oe_exp;
    int n = 0;
    time t0 = 0;
    exp_t e;
    bits = '0; oes = '0;
    forever begin
      @(posedge mdc);
      #1;
      if (n == 0) t0 = $time;
      if (n == 1) chk(($time - t0) == 2*HALF*CLK_PERIOD, "R6 mdc period",
                      64'($time - t0), 64'(2*HALF*CLK_PERIOD));
      bits = {bits[62:0], (mdio_oe ? mdio_out : phy_drv)};
      oes  = {oes[62:0], mdio_oe};
      phy_drv = (n >= 47 && n <= 62) ? resp_data[62-n] : 1'b1;
      n++;
      if (n == 64) begin
        n = 0;
        frames_seen++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected frame", bits, 64'h0);
        end else begin
          e = exp_q.pop_front();
          chk(bits[63:18] == e.bits[63:18], "R3 header", 64'(bits[63:18]), 64'(e.bits[63:18]));
          if (!e.rd)
            chk(bits[17:0] == e.bits[17:0], "R4 ta+data", 64'(bits[17:0]), 64'(e.bits[17:0]));
          mask   = {64{1'b1}};
          oe_exp = e.rd ? (mask << 18) : mask;
          chk(oes == oe_exp, e.rd ? "R5 oe release" : "R4 oe drive", oes, oe_exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    reg_read(3'h0, v);
    chk(v == 16'h1000, "R9 status", 64'(v), 64'h1000);
    chk(!mdc && !mdio_oe, "R9 mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    // R1 register map
    reg_read(3'h4, v);
    chk(v == 16'h0, "R1 rdata reset", 64'(v), 64'h0);
    reg_write(3'h2, 16'hA5C3);
    reg_read(3'h2, v);
    chk(v == 16'hA5C3, "R1 wdata readback", 64'(v), 64'hA5C3);
    reg_read(3'h6, v);
    chk(v == 16'h0, "R1 unmapped", 64'(v), 64'h0);

    // write transaction, capture and busy-ignore
    run_cmd(2'd1, 5'h11, 5'h03, 16'hA5C3);
    reg_read(3'h0, v);
    chk(v[12] == 1'b0, "R2 busy", 64'(v[12]), 64'd0);
    reg_write(3'h2, 16'hFFFF);  // R4: must not alter frame in flight
    reg_write(3'h0, {4'h0, 2'd2, 5'h1F, 5'h1F});  // R7: ignored while busy
    reg_read(3'h0, v);
    chk(v[11:0] == {2'd1, 5'h11, 5'h03}, "R7 busy cmd kept", 64'(v[11:0]),
        64'({2'd1, 5'h11, 5'h03}));
    wait_idle();

    // read transaction
    run_cmd(2'd2, 5'h01, 5'h02, 16'hBEEF);
    wait_idle();
    reg_read(3'h4, v);
    chk(v == 16'hBEEF, "R5 read data", 64'(v), 64'hBEEF);

    // write leaves read data alone
    run_cmd(2'd1, 5'h00, 5'h1F, 16'h8001);
    wait_idle();
    reg_read(3'h4, v);
    chk(v == 16'hBEEF, "R8 rdata hold", 64'(v), 64'hBEEF);

    // invalid opcodes
    reg_write(3'h0, {4'h0, 2'd0, 5'h05, 5'h05});
    repeat (4) @(negedge clk);
    reg_read(3'h0, v);
    chk(v[12] == 1'b1, "R7 op0 ignored", 64'(v[12]), 64'd1);
    reg_write(3'h0, {4'h0, 2'd3, 5'h05, 5'h05});
    repeat (4) @(negedge clk);
    reg_read(3'h0, v);
    chk(v[12] == 1'b1, "R7 op3 ignored", 64'(v[12]), 64'd1);
    repeat (3*HALF) @(negedge clk);
    chk(!mdc && !mdio_oe, "R10 idle quiet", {62'd0, mdc, mdio_oe}, 64'd0);

    // boundary read: all-ones address fields, LSB-only data
    run_cmd(2'd2, 5'h1F, 5'h1F, 16'h0001);
    wait_idle();
    reg_read(3'h4, v);
    chk(v == 16'h0001, "R5 read lsb", 64'(v), 64'h0001);

    repeat (4*HALF) @(negedge clk);
    chk(exp_q.size() == 0, "R3 frames pending", 64'(exp_q.size()), 64'd0);
    chk(frames_seen == frames_exp, "R7 frame count", 64'(frames_seen), 64'(frames_exp));
    summary();
  end
endmodule